// File: doc/BRIEF.md
# Synchronous Byte-Lane SRAM

This block is a clocked static memory of 32-bit words with four independently writable byte lanes. It is intended as a drop-in storage model for simulation and for FPGA builds. Each access is opened by one of two active-low address strobes while the chip select is low:

- The processor strobe always opens a read.
- The controller strobe opens a cycle that reads or writes in the same clock, depending on the write inputs.

Cycles with no strobe continue at the held address. On those clocks the write inputs may turn the cycle into a write.

Write qualification has two levels. An active-low global write forces all four lanes to be written. When the global write is inactive, an active-low byte-write enable hands control to four active-low lane selects. Read data passes through an output register. The bus drive enable is combinational: it follows an asynchronous output-enable input, and it is forced low whenever a write is being requested.

Top module: `sram_bytewr`

## Requirements
- R1: Lane i occupies data bits 8*i+7 down to 8*i, and bit i of `lane_n` is its active-low select. Lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R2: In a write-capable cycle with `gwr_n` low, all four lanes are written, whatever the values of `bwr_n` and `lane_n`.
- R3: With `gwr_n` high and `bwr_n` high, the cycle is a read and `lane_n` has no effect on the stored data.
- R4: With `gwr_n` high and `bwr_n` low, exactly the lanes whose `lane_n` bit is 0 are written. When `lane_n` is 4'b1111, nothing is written and the cycle is a read.
- R5: A clock with `cpu_stb_n` low and `cs_n` low is always a read at `addr`, whatever the write inputs are.
- R6: A write can happen in two ways. It can happen on a clock with `ctl_stb_n` low and `cs_n` low, at `addr`. It can also happen on a later clock with no strobe, at the address held from the last strobe that opened a cycle.
- R7: While a write is being requested in an open cycle, `dq_oe` is 0, even when `oe_n` is low.
- R8: `dq_oe` follows `oe_n` combinationally, with no clock edge needed. It is 0 while `oe_n` is high. A strobe with `cs_n` high closes the cycle: `dq_oe` is 0 after that edge, and later clocks with no strobe write nothing.
- R9: On a read clock, `dq_out` shows the word at the effective address once that edge has passed. On clocks with no strobe, the address captured last is kept and the `addr` port is ignored.
- R10: After reset, `dq_oe` is 0 and no cycle is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, sampled with a strobe |
| cpu_stb_n | input | 1 | Active-low processor address strobe (forces read) |
| ctl_stb_n | input | 1 | Active-low controller address strobe |
| addr | input | AW | Word address |
| gwr_n | input | 1 | Active-low global write (all lanes) |
| bwr_n | input | 1 | Active-low byte-write enable |
| lane_n | input | LANES | Active-low per-lane write selects |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Drive enable for an external tri-state buffer |

## Verification
The lane decode is tried with all sixteen select patterns written over a known background word. Each readback shows which lanes were replaced, which separates lane order from select polarity. The global write is applied with selects that request no lanes or only some lanes, which shows the override. A byte-write-disabled cycle with every select low shows that the selects are ignored. A processor strobe arriving with a full write request, followed by a strobe-free write, separates the forced read from the write at the held address. Further cases toggle `oe_n` between edges and issue writes after a deselect.

// File: rtl/sram_bw_pkg.sv
package sram_bw_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_t;
endpackage

// File: rtl/bw_lane_decode.sv
module bw_lane_decode #(
  parameter int LANES = 4
) (
  input  logic             gwr_n,
  input  logic             bwr_n,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] lane_req
);
  // Global write overrides; otherwise byte enable gates the lane selects.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_req[i] = !gwr_n || (!bwr_n && !lane_n[i]);
  end
endmodule

// File: rtl/bw_cycle_ctl.sv
module bw_cycle_ctl
  import sram_bw_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             cpu_stb_n,
  input  logic             ctl_stb_n,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] lane_req,
  output logic [AW-1:0]    eff_addr,
  output logic [LANES-1:0] we,
  output cyc_t             kind
);
  logic [AW-1:0] addr_q;
  logic          live_q;
  logic          strobe, opening, closing, live_now, may_write;

  assign strobe    = !cpu_stb_n || !ctl_stb_n;
  assign opening   = strobe && !cs_n;
  assign closing   = strobe && cs_n;
  assign live_now  = opening || (!strobe && live_q);
  // Processor strobe always opens a read.
  assign may_write = live_now && cpu_stb_n;
  assign eff_addr  = opening ? addr : addr_q;
  assign we        = may_write ? lane_req : '0;

  always_comb begin
    if (!live_now)     kind = CYC_IDLE;
    else if (|we)      kind = CYC_WRITE;
    else               kind = CYC_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      live_q <= 1'b0;
    end else begin
      if (opening) addr_q <= addr;
      if (opening)      live_q <= 1'b1;
      else if (closing) live_q <= 1'b0;
    end
  end

  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stb_n && ctl_stb_n) |=> $stable(addr_q));

  a_r5_cpu_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stb_n && !cs_n) |-> (kind != CYC_WRITE));

  a_r8_closed_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && cs_n) |=> (cpu_stb_n && ctl_stb_n) |-> (we == '0));
endmodule

// File: rtl/bw_mem_array.sv
module bw_mem_array #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic [LANES-1:0]        we,
  input  logic                    re,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar i = 0; i < LANES; i++) begin : g_bank
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[i]) bank[addr] <= wdata[i*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rd_q <= '0;
      else if (re) rd_q <= bank[addr];
    end

    assign rdata[i*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sram_bytewr.sv
module sram_bytewr
  import sram_bw_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    cpu_stb_n,
  input  logic                    ctl_stb_n,
  input  logic [AW-1:0]           addr,
  input  logic                    gwr_n,
  input  logic                    bwr_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  logic [LANES-1:0] lane_req, we;
  logic [AW-1:0]    eff_addr;
  cyc_t             kind;
  logic             rdv_q;

  bw_lane_decode #(.LANES(LANES)) u_dec (
    .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_n(lane_n), .lane_req(lane_req)
  );

  bw_cycle_ctl #(.AW(AW), .LANES(LANES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cpu_stb_n(cpu_stb_n),
    .ctl_stb_n(ctl_stb_n), .addr(addr), .lane_req(lane_req),
    .eff_addr(eff_addr), .we(we), .kind(kind)
  );

  bw_mem_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .addr(eff_addr), .we(we),
    .re(kind == CYC_READ), .wdata(dq_in), .rdata(dq_out)
  );

  // Output stage holds valid data only after a read edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdv_q <= 1'b0;
    else        rdv_q <= (kind == CYC_READ);
  end

  // Asynchronous enable, masked while a write is requested.
  assign dq_oe = !oe_n && rdv_q && (kind != CYC_WRITE);

  a_r7_quiet_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|we) |-> !dq_oe);

  a_r4_lane_subset: assert property (@(posedge clk) disable iff (!rst_n)
    gwr_n |-> ((we & lane_n) == '0));

  a_r2_global_all: assert property (@(posedge clk) disable iff (!rst_n)
    (!gwr_n && !ctl_stb_n && !cs_n) |-> (&we));

  a_r8_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((!cpu_stb_n || !ctl_stb_n) && cs_n) |=> !dq_oe);
endmodule

// File: tb/sram_bytewr_test.sv
module sram_bytewr_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b0, cpu_stb_n = 1'b1, ctl_stb_n = 1'b1;
  logic [7:0]  addr = '0;
  logic        gwr_n = 1'b1, bwr_n = 1'b1, oe_n = 1'b0;
  logic [3:0]  lane_n = 4'hF;
  logic [31:0] dq_in = '0;
  logic [31:0] dq_out;
  logic        dq_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] ref_mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_bytewr uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cpu_stb_n(cpu_stb_n),
    .ctl_stb_n(ctl_stb_n), .addr(addr), .gwr_n(gwr_n), .bwr_n(bwr_n),
    .lane_n(lane_n), .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus clock: drive at negedge, pass a posedge, return at next negedge.
  task automatic bus(input logic cpu, input logic ctl, input logic cs,
                     input logic [7:0] a, input logic gw, input logic bw,
                     input logic [3:0] s, input logic [31:0] d);
    cpu_stb_n = cpu; ctl_stb_n = ctl; cs_n = cs; addr = a;
    gwr_n = gw; bwr_n = bw; lane_n = s; dq_in = d;
    @(posedge clk);
    @(negedge clk);
    cpu_stb_n = 1'b1; ctl_stb_n = 1'b1; cs_n = 1'b0;
    gwr_n = 1'b1; bwr_n = 1'b1; lane_n = 4'hF;
  endtask

  task automatic wr_full(input logic [7:0] a, input logic [31:0] d);
    bus(1'b1, 1'b0, 1'b0, a, 1'b0, 1'b1, 4'hF, d);
    ref_mem[a] = d;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    bus(1'b0, 1'b1, 1'b0, a, 1'b1, 1'b1, 4'hF, 32'h0);
    chk(tag, dq_out, ref_mem[a]);
    chk(tag, {31'b0, dq_oe}, 32'd1);
  endtask

  task automatic t_reset;
    chk("R10 dq_oe after reset", {31'b0, dq_oe}, 32'd0);
  endtask

  task automatic t_global;
    bus(1'b1, 1'b0, 1'b0, 8'd5, 1'b0, 1'b1, 4'hF, 32'hDEADBEEF);
    ref_mem[5] = 32'hDEADBEEF;
    rd(8'd5, "R2 global write, selects idle");
    bus(1'b1, 1'b0, 1'b0, 8'd5, 1'b0, 1'b0, 4'b1010, 32'h0BADF00D);
    ref_mem[5] = 32'h0BADF00D;
    rd(8'd5, "R2 global write over partial selects");
  endtask

  task automatic t_patterns;
    for (int p = 0; p < 16; p++) begin
      logic [31:0] bg, nw, ex;
      bg = 32'hA5A5A5A5 ^ p;
      nw = 32'h11223344 + (p << 4);
      wr_full(8'(16 + p), bg);
      bus(1'b1, 1'b0, 1'b0, 8'(16 + p), 1'b1, 1'b0, 4'(p), nw);
      for (int i = 0; i < 4; i++) begin
        ex[i*8 +: 8] = p[i] ? bg[i*8 +: 8] : nw[i*8 +: 8];
      end
      ref_mem[16 + p] = ex;
      rd(8'(16 + p), (p == 15) ? "R4 all selects high no write" : "R1 R4 lane pattern");
    end
  endtask

  task automatic t_bwe_off;
    wr_full(8'd60, 32'h5A5A1234);
    bus(1'b1, 1'b0, 1'b0, 8'd60, 1'b1, 1'b1, 4'h0, 32'hFFFF0000);
    chk("R3 byte enable off is read", dq_out, 32'h5A5A1234);
    rd(8'd60, "R3 selects ignored");
  endtask

  task automatic t_cpu_strobe;
    wr_full(8'd40, 32'hCAFE0001);
    bus(1'b0, 1'b1, 1'b0, 8'd40, 1'b0, 1'b0, 4'h0, 32'h99999999);
    chk("R5 cpu strobe reads", dq_out, 32'hCAFE0001);
    chk("R5 cpu strobe drives", {31'b0, dq_oe}, 32'd1);
    // Write on following clock at held address.
    addr = 8'd99; gwr_n = 1'b0; dq_in = 32'h7777ABCD;
    #1;
    chk("R7 bus off during write request", {31'b0, dq_oe}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    gwr_n = 1'b1;
    ref_mem[40] = 32'h7777ABCD;
    rd(8'd40, "R6 write at held address");
  endtask

  task automatic t_hold;
    wr_full(8'd41, 32'h41414141);
    wr_full(8'd42, 32'h42424242);
    rd(8'd41, "R9 read timing");
    bus(1'b1, 1'b1, 1'b0, 8'd42, 1'b1, 1'b1, 4'hF, 32'h0);
    chk("R9 address held without strobe", dq_out, 32'h41414141);
  endtask

  task automatic t_oe;
    rd(8'd42, "R8 read before oe toggle");
    oe_n = 1'b1;
    #2;
    chk("R8 oe high releases bus", {31'b0, dq_oe}, 32'd0);
    oe_n = 1'b0;
    #2;
    chk("R8 oe low drives bus", {31'b0, dq_oe}, 32'd1);
  endtask

  task automatic t_deselect;
    rd(8'd42, "R8 read before deselect");
    bus(1'b1, 1'b0, 1'b1, 8'd42, 1'b1, 1'b1, 4'hF, 32'h0);
    chk("R8 deselect releases bus", {31'b0, dq_oe}, 32'd0);
    bus(1'b1, 1'b1, 1'b0, 8'd42, 1'b0, 1'b1, 4'hF, 32'hBBBBBBBB);
    rd(8'd42, "R8 no write while deselected");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_global;
    t_patterns;
    t_bwe_off;
    t_cpu_strobe;
    t_hold;
    t_oe;
    t_deselect;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule